// File: doc/BRIEF.md
# Peak-Hold Decimating Sample Store

This block sits behind a sampling converter and thins the sample stream before it reaches a dual-port RAM. It receives one sample on every edge of the sampling clock and writes one word per storage interval. That word is the largest sample seen during the interval, not one kept sample with the rest thrown away. A narrow spike that falls between two storage events therefore still shows up in the stored record.

Two pulses control the intervals. A seed pulse marks the first sample of an interval. That sample becomes the starting maximum, whatever was held before. A store pulse marks the last sample of an interval. The maximum, including that last sample, is then written to the RAM at the current address, and the address moves on by one. The ratio between the sampling rate and the storage rate is set at run time only by how far apart the pulses are. When both pulses are high on every sample, every sample is written unchanged.

Top module: `peak_decim_store`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `wr_en` is 0. The first write after reset goes to address 0.
- R2: A sample together with the pulses is captured on one clock edge (edge k). A store pulse captured on edge k makes `wr_en` high for exactly the cycle that follows edge k+1. In that cycle, `wr_data` is the unsigned maximum of all samples from the interval's seed sample up to and including the store sample.
- R3: A sample captured with the seed pulse high replaces the held maximum, even when it is smaller.
- R4: A sample that is not a seed replaces the held maximum only when it is strictly greater (unsigned).
- R5: With the seed and store pulses both high on every sample, each sample is written unchanged, in order, one write per sample.
- R6: Each write uses an address one greater than the previous write. The address wraps from 2^ADDR_W-1 to 0.
- R7: The sample right after a store sample starts a new interval even if the seed pulse is low.
- R8: When the store pulse stays low, no write happens, however many samples arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all logic uses its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_data | input | DATA_W | Converter sample, one per clock |
| seed_pulse | input | 1 | High on the first sample of an interval |
| store_pulse | input | 1 | High on the last sample of an interval |
| wr_en | output | 1 | RAM write strobe, one cycle per interval |
| wr_addr | output | ADDR_W | RAM write address |
| wr_data | output | DATA_W | Peak of the finished interval |

## Verification
The bench builds the block with an 8-bit sample and a 4-bit address. With only sixteen locations, a run of twenty single-sample intervals reaches the address wrap quickly, and each later address is still checked against a model counter. The 8-bit width lets the stimulus use the extreme codes 0 and 255, and lets an interval start with a seed far below the previous peak. The five-sample intervals place the peak first, in the middle and last.

// File: rtl/peak_decim_pkg.sv
// Package: shared defaults and helpers for the peak-hold sample store.
// Assumes: consumers override the defaults through their own parameters.
package peak_decim_pkg;

    localparam int DATA_W_DEF = 8;
    localparam int ADDR_W_DEF = 9;

    // Select the new sample when seeding or when it strictly beats the held value.
    function automatic logic take_new(input logic seed, input logic beats);
        return seed | beats;
    endfunction

endpackage

// File: rtl/pds_in_latch.sv
// Module: input latch. Registers the sample and both interval pulses on the
// sampling clock, so the comparator sees them aligned.
// Assumes: one sample arrives on every rising edge.
module pds_in_latch #(
    parameter int DATA_W = peak_decim_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              seed_pulse,
    input  logic              store_pulse,
    output logic [DATA_W-1:0] smp_q,
    output logic              seed_q,
    output logic              store_q
);

    // Capture the sample and its control pulses together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q   <= '0;
            seed_q  <= 1'b0;
            store_q <= 1'b0;
        end else begin
            smp_q   <= smp_data;
            seed_q  <= seed_pulse;
            store_q <= store_pulse;
        end
    end

    // R8: no store pulse during reset leaks into the pipeline.
    a_r8_store_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (store_q == $past(store_pulse)));

endmodule

// File: rtl/pds_peak_track.sv
// Module: running-maximum tracker. It compares each latched sample with the
// held peak and loads the sample on a seed, on the first sample after a
// store, or when the sample is strictly greater.
// Assumes: samples are unsigned.
module pds_peak_track #(
    parameter int DATA_W = peak_decim_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_q,
    input  logic              seed_q,
    input  logic              store_q,
    output logic [DATA_W-1:0] peak_nxt
);

    logic [DATA_W-1:0] peak_q;
    logic              fresh_q;
    logic              beats;
    logic              take;

    // Compare the sample with the held peak and pick the value to keep.
    always_comb begin
        beats    = (smp_q > peak_q);
        take     = peak_decim_pkg::take_new(seed_q | fresh_q, beats);
        peak_nxt = take ? smp_q : peak_q;
    end

    // Hold the peak, and note when the next sample opens a new interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_q  <= '0;
            fresh_q <= 1'b1;
        end else begin
            peak_q  <= peak_nxt;
            fresh_q <= store_q;
        end
    end

    // R3: a seed sample becomes the peak unconditionally.
    a_r3_seed_loads: assert property (@(posedge clk) disable iff (!rst_n)
        seed_q |=> (peak_q == $past(smp_q)));

    // R7: the sample after a store starts over.
    a_r7_restart_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        (store_q && !$past(store_q)) |=> ##1 (peak_q == $past(smp_q)));

    // R4: inside an interval the peak never drops.
    a_r4_peak_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_q && !fresh_q) |=> (peak_q >= $past(peak_q)));

    // R2: the held peak covers the latest sample.
    a_r2_peak_covers_sample: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (peak_q >= $past(smp_q)));

endmodule

// File: rtl/pds_wr_port.sv
// Module: RAM write side. On a store it registers the finished peak and the
// current address, then advances the address counter, which wraps.
// Assumes: the RAM accepts a write on every cycle where wr_en is high.
module pds_wr_port #(
    parameter int DATA_W = peak_decim_pkg::DATA_W_DEF,
    parameter int ADDR_W = peak_decim_pkg::ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_q,
    input  logic [DATA_W-1:0] peak_nxt,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic [ADDR_W-1:0] addr_cnt;

    // Issue one write per store and step the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_cnt <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= store_q;
            if (store_q) begin
                wr_data  <= peak_nxt;
                wr_addr  <= addr_cnt;
                addr_cnt <= addr_cnt + 1'b1;
            end
        end
    end

    // R1: reset leaves the strobe low and the counter at zero.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!wr_en && addr_cnt == '0));

    // R6: every store advances the address by one, wrapping.
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        store_q |=> (addr_cnt == $past(addr_cnt) + 1'b1));

    // R8: the strobe follows the store and nothing else.
    a_r8_strobe_tracks_store: assert property (@(posedge clk) disable iff (!rst_n)
        !store_q |=> !wr_en);

    // R2: the strobe lasts one cycle for an isolated store.
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !store_q) |=> !wr_en);

endmodule

// File: rtl/peak_decim_store.sv
// Module: peak-hold decimating sample store (top). Latches samples, tracks
// the interval maximum and writes it to a dual-port RAM on each store pulse.
// Assumes: seed and store pulses come from a rate generator in the same clock
// domain; the storage interval length is set only by the pulse spacing.
module peak_decim_store #(
    parameter int DATA_W = peak_decim_pkg::DATA_W_DEF,
    parameter int ADDR_W = peak_decim_pkg::ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              seed_pulse,
    input  logic              store_pulse,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] smp_q;
    logic              seed_q;
    logic              store_q;
    logic [DATA_W-1:0] peak_nxt;

    pds_in_latch #(.DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data),
        .seed_pulse(seed_pulse), .store_pulse(store_pulse),
        .smp_q(smp_q), .seed_q(seed_q), .store_q(store_q)
    );

    pds_peak_track #(.DATA_W(DATA_W)) u_track (
        .clk(clk), .rst_n(rst_n), .smp_q(smp_q), .seed_q(seed_q),
        .store_q(store_q), .peak_nxt(peak_nxt)
    );

    pds_wr_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .store_q(store_q), .peak_nxt(peak_nxt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // R5: a combined seed and store writes that very sample.
    a_r5_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_q && store_q) |=> (wr_en && wr_data == $past(smp_q)));

endmodule

// File: tb/test_peak_decim_store.sv
// Directed bench for the peak-hold decimating sample store.
module test_peak_decim_store;

    localparam int DW = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          seed_pulse = 1'b0;
    logic          store_pulse = 1'b0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_addr = 0;

    logic [DW-1:0] cap_data [0:63];
    logic [AW-1:0] cap_addr [0:63];
    int            cap_n = 0;
    logic [DW-1:0] exp_q [0:63];
    int            exp_n = 0;

    always #2.5 clk = ~clk;

    peak_decim_store #(.DATA_W(DW), .ADDR_W(AW)) i_peak_decim_store (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data),
        .seed_pulse(seed_pulse), .store_pulse(store_pulse),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Record every write, sampled just after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && wr_en && cap_n < 64) begin
            cap_data[cap_n] = wr_data;
            cap_addr[cap_n] = wr_addr;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int d, input logic sd, input logic st);
        @(negedge clk);
        smp_data    = DW'(d);
        seed_pulse  = sd;
        store_pulse = st;
    endtask

    task automatic settle();
        @(negedge clk);
        seed_pulse  = 1'b0;
        store_pulse = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_w(input int v);
        exp_q[exp_n] = DW'(v);
        exp_n++;
    endtask

    // Compare captured writes with the model list and model address.
    task automatic compare(input string req);
        check({req, " write count"}, cap_n == exp_n, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            check({req, " data"}, cap_data[i] == exp_q[i], cap_data[i], exp_q[i]);
            check("R6 address", cap_addr[i] == AW'(exp_addr), cap_addr[i], exp_addr % (1 << AW));
            exp_addr = (exp_addr + 1) % (1 << AW);
        end
        cap_n = 0;
        exp_n = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 strobe in reset", wr_en == 1'b0, wr_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobe after reset", wr_en == 1'b0, wr_en, 0);
        check("R1 no write", cap_n == 0, cap_n, 0);
    endtask

    task automatic t_latency();
        drive(77, 1'b1, 1'b1);
        @(negedge clk);
        seed_pulse = 1'b0; store_pulse = 1'b0;
        check("R2 not yet written", wr_en == 1'b0, wr_en, 0);
        @(negedge clk);
        check("R2 strobe cycle", wr_en == 1'b1, wr_en, 1);
        check("R2 data", wr_data == 8'd77, wr_data, 77);
        check("R1 first address", wr_addr == '0, wr_addr, 0);
        @(negedge clk);
        check("R2 single strobe", wr_en == 1'b0, wr_en, 0);
        cap_n = 0;
        exp_addr = 1;
    endtask

    task automatic t_peak_intervals();
        drive(10, 1, 0); drive(50, 0, 0); drive(30, 0, 0); drive(50, 0, 0); drive(20, 0, 1);
        expect_w(50);
        drive(200, 1, 0); drive(100, 0, 0); drive(90, 0, 0); drive(80, 0, 0); drive(70, 0, 1);
        expect_w(200);
        drive(5, 1, 0); drive(6, 0, 0); drive(7, 0, 0); drive(8, 0, 0); drive(9, 0, 1);
        expect_w(9);
        drive(0, 1, 0); drive(0, 0, 0); drive(0, 0, 0); drive(0, 0, 0); drive(255, 0, 1);
        expect_w(255);
        settle();
        compare("R2 R3 R4 peak per interval");
    endtask

    task automatic t_passthrough();
        drive(3, 1, 1); drive(250, 1, 1); drive(0, 1, 1); drive(17, 1, 1); drive(128, 1, 1);
        expect_w(3); expect_w(250); expect_w(0); expect_w(17); expect_w(128);
        settle();
        compare("R5 every sample stored");
    endtask

    task automatic t_restart();
        drive(240, 1, 0); drive(60, 0, 1);
        expect_w(240);
        drive(40, 0, 0); drive(10, 0, 0); drive(20, 0, 1);
        expect_w(40);
        settle();
        compare("R7 restart without seed");
    endtask

    task automatic t_no_store();
        for (int i = 0; i < 10; i++) drive(i * 20, (i == 0), 0);
        settle();
        check("R8 no write without store", cap_n == 0, cap_n, 0);
        cap_n = 0;
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 20; i++) begin
            drive(i + 100, 1, 1);
            expect_w(i + 100);
        end
        settle();
        compare("R6 wrap run");
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_latency();
        t_peak_intervals();
        t_passthrough();
        t_restart();
        t_no_store();
        t_wrap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule